// File: doc/BRIEF.md
# Tuner Control Register Slave on a Two-Wire Bus

This block is the serial control port of a tuner. An external bus master reaches it over a two-wire, I2C-compatible bus at up to 400 kHz. The block answers to one fixed 7-bit device address. It holds eight control bytes that the master can only write, and it returns two status bytes that the master can only read.

A write transfer has three parts. It starts with the device address and the write bit. A register index follows. Data bytes then fill successive registers, and the index advances by one after each accepted byte until the master sends STOP.

A read transfer has no index. The block always sends the first status byte and then the second. The first status byte carries a power-cycled flag. This flag is set at reset and cleared when a STOP ends a read.

Whenever a byte lands in the low byte of the synthesizer feedback divider, the block emits a one-cycle pulse. Downstream logic uses this pulse to start an oscillator band search.

The bus lines are sampled on the system clock, which must be much faster than the bus. SDA is driven open-drain: one input carries the line level and one output enables the pull-down. The block never stretches SCL, and it supports neither general call nor 10-bit addressing.

Top module: `tuner_ctl_slave`

## Requirements
- R1: The block acknowledges only the address byte 0xC0 (write) or 0xC1 (read): device address 7'b1100000 in bits 7..1, with bit 0 = 1 meaning read. After any other address byte it leaves SDA released until the next START.
- R2: In a write, the byte after the address is a register index and is always acknowledged. Each later data byte (MSB first) is acknowledged and stored at the current index, and the index then rises by one until STOP.
- R3: Register index i appears on `regs_flat[8*i+7:8*i]`. Indices run 0 test, 1 PLL, 2 VCO, 3 control, 4 crystal divide, 5 reference divider, 6 feedback divider high, 7 feedback divider low. After reset, index 5 = 0x38, index 6 = 0x53 and index 7 = 0xF8 (N[4:0] = 5'b11111 in bits 7..3, giving N = 2687). All other registers reset to 0x00.
- R4: A data byte whose index is 8 or above is not acknowledged and changes no register. The block then leaves SDA released until the next START.
- R5: A read returns two bytes, MSB first. Status byte 1 is {3'b000, `cp_sel_in`[1:0], power flag, `vas_flags_in`[1:0]}. Status byte 2 is `stat2_in`.
- R6: The power flag is 1 after reset. It is cleared by a STOP that ends a read, and a STOP that ends a write leaves it unchanged.
- R7: `band_search_go` is high for exactly one cycle for each acknowledged data byte written to index 7, and never in any other case.
- R8: A START, including a repeated START in the middle of a transfer, abandons any partly received byte and restarts address reception.
- R9: `sda_pull` is 0 after reset and while the bus is idle. It is asserted only in an acknowledge slot of the slave or while a 0 bit of a status byte is being sent.
- R10: If the master does not acknowledge status byte 1, the block sends nothing more and keeps SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 = pull SDA low |
| cp_sel_in | input | 2 | Charge-pump current field for status byte 1 |
| vas_flags_in | input | 2 | Band-search flags for status byte 1 |
| stat2_in | input | 8 | Status byte 2 contents |
| regs_flat | output | 64 | All eight control registers, index i at bits 8*i+7:8*i |
| band_search_go | output | 1 | One-cycle pulse after a write to index 7 |

## Verification
A wrong receive state or a wrong bit counter shows up inside a single byte slot: the ACK is missing or misplaced in the ninth clock of that byte. A wrong index pointer shows up after the next STOP, as a byte stored in the wrong lane of `regs_flat` or as an ACK where a NACK was due. A stuck or wrongly cleared power flag shows up in bit 2 of the next status byte 1 that is read. A corrupted read shift register shows up in the very byte being sent.

// File: rtl/tcs_pkg.sv
// Shared types for the tuner control slave.
// Assumes an eight-bit byte on the bus and one state type shared by the protocol engine.
package tcs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/tcs_line_sync.sv
// Brings SCL and SDA into the clock domain and detects edges and bus conditions.
// Assumes clk is at least ten times faster than SCL; both lines idle high.
module tcs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_v;
    logic [LINES-1:0] now_v;
    logic [LINES-1:0] old_v;

    assign raw_v = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;
        // Shift the line through the synchroniser plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-1:0], raw_v[g]};
        end
        assign now_v[g] = pipe[STAGES-1];
        assign old_v[g] = pipe[STAGES];
    end

    assign scl_rise  = now_v[0] & ~old_v[0];
    assign scl_fall  = ~now_v[0] & old_v[0];
    assign start_det = now_v[0] & old_v[0] & old_v[1] & ~now_v[1];
    assign stop_det  = now_v[0] & old_v[0] & ~old_v[1] & now_v[1];
    assign sda_bit   = now_v[1];

    assert_cond_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det}));
endmodule

// File: rtl/tcs_bus_engine.sv
// Protocol engine: address match, index and data reception, ACK generation,
// and the two-byte status dump. It issues write strobes to the register bank.
// Assumes edges from tcs_line_sync; a START or STOP overrides every state.
module tcs_bus_engine
    import tcs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100000,
    parameter int         NREG     = 8,
    localparam int        SEL_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [BYTE_W-1:0] stat1,
    input  logic [BYTE_W-1:0] stat2,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              read_stop
);
    localparam logic [BYTE_W-1:0] NREG_B = BYTE_W'(NREG);

    bus_state_t        state;
    logic [2:0]        bitcnt;
    logic              byte_full;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] idx;
    logic              is_read;
    logic              second_sent;
    logic              rd_more;

    // Main protocol sequencer, advanced by SCL edges and bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bitcnt      <= '0;
            byte_full   <= 1'b0;
            shreg       <= '0;
            idx         <= '0;
            is_read     <= 1'b0;
            second_sent <= 1'b0;
            rd_more     <= 1'b0;
            sda_pull    <= 1'b0;
            wr_en       <= 1'b0;
            wr_idx      <= '0;
            wr_data     <= '0;
            read_stop   <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            read_stop <= 1'b0;
            if (start_det) begin
                state     <= ST_ADDR;
                bitcnt    <= '0;
                byte_full <= 1'b0;
                is_read   <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (stop_det) begin
                read_stop <= is_read;
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                is_read   <= 1'b0;
                sda_pull  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INDEX, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_bit};
                            bitcnt <= 3'(bitcnt + 3'd1);
                            if (bitcnt == 3'd7) byte_full <= 1'b1;
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_pull <= 1'b1;
                                    is_read  <= shreg[0];
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_INDEX) begin
                                idx      <= shreg;
                                sda_pull <= 1'b1;
                                state    <= ST_INDEX_ACK;
                            end else if (idx < NREG_B) begin
                                sda_pull <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                shreg       <= stat1;
                                sda_pull    <= ~stat1[BYTE_W-1];
                                second_sent <= 1'b0;
                                state       <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_INDEX;
                            end
                        end
                    end
                    ST_INDEX_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            wr_en    <= 1'b1;
                            wr_idx   <= idx[SEL_W-1:0];
                            wr_data  <= shreg;
                            idx      <= idx + 8'd1;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && !byte_full) begin
                            bitcnt <= 3'(bitcnt + 3'd1);
                            if (bitcnt == 3'd7) byte_full <= 1'b1;
                        end else if (scl_fall) begin
                            if (byte_full) begin
                                byte_full <= 1'b0;
                                sda_pull  <= 1'b0;
                                state     <= ST_RACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            rd_more <= ~sda_bit & ~second_sent;
                        end else if (scl_fall) begin
                            if (rd_more) begin
                                shreg       <= stat2;
                                sda_pull    <= ~stat2[BYTE_W-1];
                                second_sent <= 1'b1;
                                bitcnt      <= '0;
                                state       <= ST_RDATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);
    assert_skip_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_pull);
    assert_start_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && !sda_pull && !byte_full));
    assert_write_not_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !is_read);
endmodule

// File: rtl/tcs_reg_bank.sv
// Control register storage with reset defaults, the band-search pulse and the
// power-cycled flag. Assumes one write strobe per accepted byte from the engine.
module tcs_reg_bank #(
    parameter int         NREG     = 8,
    parameter int         RDIV_IDX = 5,
    parameter int         NHI_IDX  = 6,
    parameter int         NLO_IDX  = 7,
    parameter logic [7:0] RDIV_DEF = 8'h38,
    parameter logic [7:0] NHI_DEF  = 8'h53,
    parameter logic [7:0] NLO_DEF  = 8'hF8,
    localparam int        SEL_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              read_stop,
    output logic [NREG*8-1:0] regs_flat,
    output logic              search_go,
    output logic              pwr_flag
);
    localparam logic [SEL_W-1:0] NLO_SEL = SEL_W'(NLO_IDX);

    logic [7:0] regs [NREG];

    function automatic logic [7:0] reset_val(input int i);
        if (i == RDIV_IDX)     return RDIV_DEF;
        else if (i == NHI_IDX) return NHI_DEF;
        else if (i == NLO_IDX) return NLO_DEF;
        else                   return 8'h00;
    endfunction

    // Store accepted bytes; load defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= reset_val(i);
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Pulse when the feedback divider low byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n) search_go <= 1'b0;
        else        search_go <= wr_en && (wr_idx == NLO_SEL);
    end

    // Power-cycled flag: set by reset, cleared by a STOP closing a read.
    always_ff @(posedge clk) begin
        if (!rst_n)         pwr_flag <= 1'b1;
        else if (read_stop) pwr_flag <= 1'b0;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        search_go |=> !search_go);
    assert_pwr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_flag |=> !pwr_flag);
    assert_pwr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        read_stop |=> !pwr_flag);
endmodule

// File: rtl/tuner_ctl_slave.sv
// Top of the tuner control slave: line synchroniser, protocol engine and
// register bank. Assumes an open-drain SDA with an external pull-up.
module tuner_ctl_slave #(
    parameter logic [6:0] DEV_ADDR = 7'b1100000,
    parameter int         NREG     = 8,
    parameter int         SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic [1:0]        cp_sel_in,
    input  logic [1:0]        vas_flags_in,
    input  logic [7:0]        stat2_in,
    output logic [NREG*8-1:0] regs_flat,
    output logic              band_search_go
);
    localparam int SEL_W = $clog2(NREG);

    logic             scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic             wr_en, read_stop, pwr_flag;
    logic [SEL_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       stat1;

    assign stat1 = {3'b000, cp_sel_in, pwr_flag, vas_flags_in};

    tcs_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
    );

    tcs_bus_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
        .stat1(stat1), .stat2(stat2_in), .sda_pull(sda_pull),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .read_stop(read_stop)
    );

    tcs_reg_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .read_stop(read_stop),
        .regs_flat(regs_flat), .search_go(band_search_go), .pwr_flag(pwr_flag)
    );
endmodule

// File: tb/tuner_ctl_slave_test.sv
// Bench for tuner_ctl_slave: a bus-master model drives random and directed
// transfers and compares ACKs, registers, pulses and status bytes with a model.
module tuner_ctl_slave_test;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [1:0]  cp_sel_in = 2'b00;
    logic [1:0]  vas_flags_in = 2'b00;
    logic [7:0]  stat2_in = 8'h00;
    logic [63:0] regs_flat;
    logic        band_search_go;
    logic        sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int exp_pulses = 0;
    bit done = 1'b0;
    logic [7:0] mdl [8];
    logic       mdl_pwr;

    assign sda_line = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    tuner_ctl_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull(sda_pull), .cp_sel_in(cp_sel_in), .vas_flags_in(vas_flags_in),
        .stat2_in(stat2_in), .regs_flat(regs_flat), .band_search_go(band_search_go)
    );

    always @(posedge clk) if (rst_n && band_search_go) pulses++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] flat_model();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    function automatic logic [7:0] exp_stat1(input logic [1:0] cp, input logic pw, input logic [1:0] vf);
        return {3'b000, cp, pw, vf};
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        s = sda_line;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b1;
        wait_q();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_low);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack_low = ~s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~master_ack, s);
    endtask

    // Write transfer from start_idx with cnt random bytes, checked against the model.
    task automatic write_txn(input int start_idx, input int cnt);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hC0, a);
        check("R1 write address ack", {63'd0, a}, 64'd1);
        send_byte(8'(start_idx), a);
        check("R2 index ack", {63'd0, a}, 64'd1);
        for (int k = 0; k < cnt; k++) begin
            d = 8'($urandom);
            send_byte(d, a);
            if (start_idx + k < 8) begin
                check("R2 data ack", {63'd0, a}, 64'd1);
                mdl[start_idx + k] = d;
                if (start_idx + k == 7) exp_pulses++;
            end else begin
                check("R4 out of range nack", {63'd0, a}, 64'd0);
                break;
            end
        end
        bus_stop();
        check("R2 registers after write", regs_flat, flat_model());
        check("R7 search pulse count", 64'(pulses), 64'(exp_pulses));
    endtask

    // Read transfer; second_ack selects the master response to status byte 2.
    task automatic read_txn(input logic second_ack);
        logic a;
        logic [7:0] b1, b2;
        cp_sel_in = 2'($urandom);
        vas_flags_in = 2'($urandom);
        stat2_in = 8'($urandom);
        bus_start();
        send_byte(8'hC1, a);
        check("R1 read address ack", {63'd0, a}, 64'd1);
        recv_byte(1'b1, b1);
        recv_byte(second_ack, b2);
        check("R5 status byte 1", {56'd0, b1}, {56'd0, exp_stat1(cp_sel_in, mdl_pwr, vas_flags_in)});
        check("R5 status byte 2", {56'd0, b2}, {56'd0, stat2_in});
        bus_stop();
        mdl_pwr = 1'b0;
    endtask

    initial begin
        logic a, s;
        logic [7:0] b;
        logic       quiet;
        void'($urandom(32'd7321));
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        mdl[5] = 8'h38;
        mdl[6] = 8'h53;
        mdl[7] = 8'hF8;
        mdl_pwr = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 reset defaults", regs_flat, flat_model());
        check("R9 sda released after reset", {63'd0, sda_pull}, 64'd0);
        check("R7 no pulse after reset", {63'd0, band_search_go}, 64'd0);

        // Directed: auto-increment across 6, 7 and then into the invalid index 8.
        write_txn(6, 3);
        // Directed: index byte only, no data.
        write_txn(2, 0);

        // Random write traffic; a STOP ending a write must not clear the flag (R6).
        for (int t = 0; t < 14; t++) write_txn(int'($urandom_range(0, 7)), int'($urandom_range(1, 4)));

        read_txn(1'b0);
        check("R6 flag cleared by read stop", 64'(mdl_pwr), 64'd0);
        read_txn(1'b1);
        write_txn(7, 1);
        read_txn(1'b0);

        // R1: foreign address is ignored and nothing is driven.
        bus_start();
        send_byte(8'h42, a);
        check("R1 foreign address nack", {63'd0, a}, 64'd0);
        send_byte(8'h01, a);
        check("R1 no ack after foreign address", {63'd0, a}, 64'd0);
        send_byte(8'hAA, a);
        check("R1 no ack for data after foreign address", {63'd0, a}, 64'd0);
        bus_stop();
        check("R1 registers unchanged", regs_flat, flat_model());

        // R8: repeated START in the middle of a data byte abandons it.
        bus_start();
        send_byte(8'hC0, a);
        send_byte(8'h02, a);
        clock_bit(1'b1, s);
        clock_bit(1'b0, s);
        clock_bit(1'b1, s);
        bus_start();
        send_byte(8'hC0, a);
        check("R8 address ack after repeated start", {63'd0, a}, 64'd1);
        send_byte(8'h00, a);
        send_byte(8'h5C, a);
        mdl[0] = 8'h5C;
        bus_stop();
        check("R8 registers after repeated start", regs_flat, flat_model());

        // R10: master NACK on status byte 1 ends the dump.
        bus_start();
        send_byte(8'hC1, a);
        recv_byte(1'b0, b);
        check("R10 byte 1 before nack", {56'd0, b}, {56'd0, exp_stat1(cp_sel_in, mdl_pwr, vas_flags_in)});
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, s);
            quiet = quiet & s;
        end
        check("R10 sda released after nack", {63'd0, quiet}, 64'd1);
        bus_stop();
        check("R9 idle sda released", {63'd0, sda_pull}, 64'd0);
        check("R7 final pulse count", 64'(pulses), 64'(exp_pulses));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule